// File: doc/BRIEF.md
# Smartcard Reader Register Front-End

This block sits between a byte-wide host bus and a smartcard serial transceiver. The host reaches six registers at consecutive offsets. One reports status. Four are write-only and hold settings: a control strobe, the trigger and parity configuration, the card clock divisor, and the elementary time unit (ETU) length. The last is a data port used for both directions. The block holds the configuration values and drives them to the transceiver as steady outputs.

Received bytes go into a 16-entry receive FIFO, and the host drains it through the data register. A write to the data register hands one byte straight to the transmitter. There is no transmit buffer, so the host must poll the ready bit first. The 11-bit ETU length is loaded through two byte writes to the same offset. A read of status or data returns its value combinationally in the cycle that `busRdEn` is high. A data read removes the byte at the clock edge that ends that cycle.

Top module: `card_reg_front`

## Requirements
- R1: Offsets are 0 status, 1 control, 2 config, 3 divisor, 4 ETU and 5 data. A status read returns bit 0 = `txReady`, bit 1 = parity-error flag, bit 2 = receive FIFO empty, and zeros in bits 7..3. Reads of offsets 1-4 and of unused offsets return 0, and the read data is 0 whenever `busRdEn` is low.
- R2: A `rxParityErr` pulse sets the parity-error flag, and the flag holds. A status write with bit 1 = 0 clears it, and a status write with bit 1 = 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R3: A control write with bit 0 = 1 empties the receive FIFO, and a byte arriving in that same cycle is discarded. A control write with bit 0 = 0 has no effect.
- R4: A config write drives bit 0 to `trigTxEn`, bit 1 to `trigRxEn`, bit 2 to `trigLongEn` and bits 4..3 to `parityMode` from the next cycle on.
- R5: A divisor write drives the full byte to `clkDivisor` from the next cycle on.
- R6: The ETU value resets to 371. The first write to offset 4 captures bits 2..0 as ETU bits 10..8 and leaves `etuValue` unchanged. The second write supplies bits 7..0, and the combined value appears on `etuValue` in the next cycle. The writes then alternate in the same way.
- R7: A data write while `txReady` is high pulses `txStart` for exactly one cycle, in the next cycle, with `txByte` holding the written byte.
- R8: A data write while `txReady` is low is ignored: `txStart` stays low and `txByte` keeps its old value.
- R9: A data read while the FIFO holds bytes returns the oldest byte and removes it, so bytes come out in arrival order.
- R10: A data read while the FIFO is empty returns 0 and leaves the FIFO unchanged.
- R11: The FIFO holds 16 bytes. A byte that arrives while 16 are stored is dropped, even if a read removes a byte in that same cycle.
- R12: After reset the config bits are 0, the divisor is 0, the ETU is 371, the flag is clear, the FIFO is empty and `txStart` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, combinational |
| txReady | input | 1 | Transceiver can accept a byte |
| txStart | output | 1 | One-cycle transmit launch |
| txByte | output | 8 | Byte to transmit |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity error strobe from the receiver |
| trigTxEn | output | 1 | Trigger on transmit end enable |
| trigRxEn | output | 1 | Trigger on receive start enable |
| trigLongEn | output | 1 | Long trigger enable |
| parityMode | output | 2 | Parity mode |
| clkDivisor | output | 8 | Card clock divisor |
| etuValue | output | 11 | ETU length minus one |

## Verification
The bench compares every cycle against a behavioural model. The model tracks the FIFO as a queue, plus the flag, the ETU pair state and the settings. Received bytes are tested in three patterns: a short burst read back, a sweep past full that separates a dropped byte from a stored one, and a read together with an arrival that catches any misordering of push and pop. Data writes alternate between ready and not ready, which separates a launch from an ignored write. Two kinds of same-cycle collision are driven: flush against arrival, and flag set against flag clear. They show which action the block lets win. ETU pairs with distinct upper and lower parts show whether the halves are placed correctly and whether the value is applied too early.

// File: rtl/sc_front_pkg.sv
package sc_front_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CONTROL = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CONFIG  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_DIVISOR = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_ETU     = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DATA    = 3'd5;

  typedef struct packed {
    logic cfgLoad;
    logic divLoad;
    logic etuHiLoad;
    logic etuLoLoad;
    logic flagClear;
    logic fifoFlush;
    logic fifoPush;
    logic fifoPop;
    logic txLaunch;
  } frontStrobes_t;
endpackage

// File: rtl/sc_rx_fifo.sv
module sc_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= stepPtr(wrPtr);
      if (pop)  rdPtr <= stepPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = store[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/sc_front_ctrl.sv
module sc_front_ctrl
  import sc_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        wrLowBits,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output frontStrobes_t     strobes
);
  logic etuSecond;
  logic etuWrite;

  assign etuWrite = busWrEn && (busAddr == OFS_ETU);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         etuSecond <= 1'b0;
    else if (etuWrite) etuSecond <= ~etuSecond;
  end

  always_comb begin
    strobes = '0;
    strobes.cfgLoad   = busWrEn && (busAddr == OFS_CONFIG);
    strobes.divLoad   = busWrEn && (busAddr == OFS_DIVISOR);
    strobes.etuHiLoad = etuWrite && !etuSecond;
    strobes.etuLoLoad = etuWrite && etuSecond;
    strobes.flagClear = busWrEn && (busAddr == OFS_STATUS) && !wrLowBits[1];
    strobes.fifoFlush = busWrEn && (busAddr == OFS_CONTROL) && wrLowBits[0];
    strobes.fifoPush  = rxValid && !fifoFull && !strobes.fifoFlush;
    strobes.fifoPop   = busRdEn && (busAddr == OFS_DATA) && !fifoEmpty;
    strobes.txLaunch  = busWrEn && (busAddr == OFS_DATA) && txReady;
  end
endmodule

// File: rtl/sc_front_datapath.sv
module sc_front_datapath
  import sc_front_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ETU_W     = 11,
  parameter int ETU_RESET = 371
) (
  input  logic              clk,
  input  logic              rstN,
  input  frontStrobes_t     strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txReady,
  input  logic              rxParityErr,
  input  logic [DATA_W-1:0] fifoHead,
  input  logic              fifoEmpty,
  output logic              txStart,
  output logic [DATA_W-1:0] txByte,
  output logic [4:0]        cfgBits,
  output logic [DATA_W-1:0] clkDivisor,
  output logic [ETU_W-1:0]  etuValue
);
  localparam int ETU_HI_W = ETU_W - DATA_W;

  logic [ETU_HI_W-1:0] etuHiHold;
  logic                parityFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits    <= '0;
      clkDivisor <= '0;
      etuValue   <= ETU_W'(ETU_RESET);
      etuHiHold  <= '0;
      parityFlag <= 1'b0;
      txStart    <= 1'b0;
      txByte     <= '0;
    end else begin
      if (strobes.cfgLoad)   cfgBits    <= busWrData[4:0];
      if (strobes.divLoad)   clkDivisor <= busWrData;
      if (strobes.etuHiLoad) etuHiHold  <= busWrData[ETU_HI_W-1:0];
      if (strobes.etuLoLoad) etuValue   <= {etuHiHold, busWrData};
      if (rxParityErr)            parityFlag <= 1'b1;
      else if (strobes.flagClear) parityFlag <= 1'b0;
      txStart <= strobes.txLaunch;
      if (strobes.txLaunch) txByte <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        OFS_STATUS: busRdData = {{(DATA_W-3){1'b0}}, fifoEmpty, parityFlag, txReady};
        OFS_DATA:   busRdData = fifoEmpty ? '0 : fifoHead;
        default:    busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/card_reg_front.sv
module card_reg_front
  import sc_front_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int ETU_W      = 11,
  parameter int ETU_RESET  = 371
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txReady,
  output logic              txStart,
  output logic [DATA_W-1:0] txByte,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxParityErr,
  output logic              trigTxEn,
  output logic              trigRxEn,
  output logic              trigLongEn,
  output logic [1:0]        parityMode,
  output logic [DATA_W-1:0] clkDivisor,
  output logic [ETU_W-1:0]  etuValue
);
  frontStrobes_t     strobes;
  logic              fifoEmpty;
  logic              fifoFull;
  logic [DATA_W-1:0] fifoHead;
  logic [4:0]        cfgBits;

  sc_front_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .wrLowBits(busWrData[1:0]), .txReady(txReady),
    .rxValid(rxValid), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .strobes(strobes)
  );

  sc_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(strobes.fifoPush), .pop(strobes.fifoPop),
    .flush(strobes.fifoFlush), .din(rxByte), .head(fifoHead),
    .empty(fifoEmpty), .full(fifoFull)
  );

  sc_front_datapath #(.DATA_W(DATA_W), .ETU_W(ETU_W), .ETU_RESET(ETU_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .txReady(txReady), .rxParityErr(rxParityErr), .fifoHead(fifoHead),
    .fifoEmpty(fifoEmpty), .txStart(txStart), .txByte(txByte),
    .cfgBits(cfgBits), .clkDivisor(clkDivisor), .etuValue(etuValue)
  );

  assign trigTxEn   = cfgBits[0];
  assign trigRxEn   = cfgBits[1];
  assign trigLongEn = cfgBits[2];
  assign parityMode = cfgBits[4:3];
endmodule

// File: rtl/card_reg_front_checker.sv
module card_reg_front_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  busAddr,
  input logic        busWrEn,
  input logic [7:0]  busWrData,
  input logic        busRdEn,
  input logic [7:0]  busRdData,
  input logic        txReady,
  input logic        txStart,
  input logic [10:0] etuValue,
  input logic        fifoEmpty
);
  assert_tx_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(busWrEn && busAddr == 3'd5 && txReady));

  assert_tx_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd5 && !txReady) |=> !txStart);

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 3'd5 && fifoEmpty) |-> busRdData == 8'd0);

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd1 && busWrData[0]) |=> fifoEmpty);

  assert_etu_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(etuValue) |-> $past(busWrEn && busAddr == 3'd4));

  assert_status_pad_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 3'd0) |-> (busRdData[7:3] == 5'd0 && busRdData[0] == txReady));
endmodule

bind card_reg_front card_reg_front_checker chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .txReady(txReady), .txStart(txStart), .etuValue(etuValue),
  .fifoEmpty(fifoEmpty)
);

// File: tb/card_reg_front_test.sv
`timescale 1ns/1ps
module card_reg_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic        txReady = 1'b1;
  logic        txStart;
  logic [7:0]  txByte;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxParityErr = 1'b0;
  logic        trigTxEn, trigRxEn, trigLongEn;
  logic [1:0]  parityMode;
  logic [7:0]  clkDivisor;
  logic [10:0] etuValue;

  int checks = 0;
  int errors = 0;

  card_reg_front uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txReady(txReady), .txStart(txStart), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte), .rxParityErr(rxParityErr),
    .trigTxEn(trigTxEn), .trigRxEn(trigRxEn), .trigLongEn(trigLongEn),
    .parityMode(parityMode), .clkDivisor(clkDivisor), .etuValue(etuValue)
  );

  always #10 clk = ~clk;

  // Behavioural reference model
  logic [7:0]  qM[$];
  logic        flagM, phaseM, txStartM;
  logic [4:0]  cfgM;
  logic [7:0]  divM, txByteM;
  logic [2:0]  hiM;
  logic [10:0] etuM;

  always @(posedge clk) begin : model
    bit fullOld, emptyOld, flushed;
    if (!rstN) begin
      qM.delete(); flagM = 0; phaseM = 0; txStartM = 0; cfgM = 0;
      divM = 0; txByteM = 0; hiM = 0; etuM = 11'd371;
    end else begin
      fullOld  = (qM.size() >= 16);
      emptyOld = (qM.size() == 0);
      flushed  = 0;
      txStartM = 0;
      if (busWrEn) begin
        case (busAddr)
          3'd0: if (!busWrData[1]) flagM = 0;
          3'd1: if (busWrData[0]) begin qM.delete(); flushed = 1; end
          3'd2: cfgM = busWrData[4:0];
          3'd3: divM = busWrData;
          3'd4: begin
            if (!phaseM) hiM = busWrData[2:0];
            else etuM = {hiM, busWrData};
            phaseM = !phaseM;
          end
          3'd5: if (txReady) begin txStartM = 1; txByteM = busWrData; end
          default: ;
        endcase
      end
      if (rxParityErr) flagM = 1;
      if (busRdEn && busAddr == 3'd5 && !emptyOld) void'(qM.pop_front());
      if (rxValid && !fullOld && !flushed) qM.push_back(rxByte);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expRd;
      string tag;
      expRd = 8'd0;
      tag = "R1 read";
      if (busRdEn) begin
        if (busAddr == 3'd0) expRd = {5'd0, qM.size() == 0, flagM, txReady};
        else if (busAddr == 3'd5) begin
          expRd = (qM.size() == 0) ? 8'd0 : qM[0];
          tag = (qM.size() == 0) ? "R10 empty read" : "R9 data read";
        end
      end
      check(tag, busRdData, expRd);
      check("R7 txStart", txStart, txStartM);
      check("R8 txByte", txByte, txByteM);
      check("R4 config", {parityMode, trigLongEn, trigRxEn, trigTxEn}, cfgM);
      check("R5 divisor", clkDivisor, divM);
      check("R6 etu", etuValue, etuM);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1; busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); #1; busWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit doCheck, input logic [7:0] exp, input string tag);
    @(negedge clk); #1; busAddr = a; busRdEn = 1;
    #5; if (doCheck) check(tag, busRdData, exp);
    @(negedge clk); #1; busRdEn = 0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk); #1; rxValid = 1; rxByte = b;
    @(negedge clk); #1; rxValid = 0;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #2;
    // R12 reset state
    check("R12 etu reset", etuValue, 11'd371);
    check("R12 config reset", {parityMode, trigLongEn, trigRxEn, trigTxEn}, 5'd0);
    check("R12 divisor reset", clkDivisor, 8'd0);
    check("R12 txStart reset", txStart, 1'b0);
    rd(3'd0, 1, 8'h05, "R12 status after reset");

    // R4, R5
    wr(3'd2, 8'h1F); wr(3'd2, 8'h0A); wr(3'd2, 8'hE5);
    wr(3'd3, 8'h5A); wr(3'd3, 8'hFF);
    rd(3'd2, 1, 8'h00, "R1 write-only reads 0");
    rd(3'd7, 1, 8'h00, "R1 unused offset");

    // R6 ETU pairs
    wr(3'd4, 8'h05);
    check("R6 first write holds", etuValue, 11'd371);
    wr(3'd4, 8'h34);
    check("R6 combined", etuValue, 11'h534);
    wr(3'd4, 8'hFA); wr(3'd4, 8'h00);
    check("R6 upper only low bits", etuValue, 11'h200);

    // R7, R8
    txReady = 1; wr(3'd5, 8'hA5);
    txReady = 0; wr(3'd5, 8'h3C);
    check("R8 txByte kept", txByte, 8'hA5);
    txReady = 1; wr(3'd5, 8'h69);
    rd(3'd0, 1, 8'h05, "R1 status ready");
    txReady = 0;
    rd(3'd0, 1, 8'h04, "R1 status not ready");
    txReady = 1;

    // R9, R10
    rxPush(8'h11); rxPush(8'h22); rxPush(8'h33);
    rd(3'd5, 1, 8'h11, "R9 first");
    rd(3'd5, 1, 8'h22, "R9 second");
    rd(3'd5, 1, 8'h33, "R9 third");
    rd(3'd5, 1, 8'h00, "R10 empty read");
    rd(3'd0, 1, 8'h05, "R10 still empty");

    // R11 overflow
    for (int i = 0; i < 17; i++) rxPush(8'h40 + 8'(i));
    for (int i = 0; i < 16; i++) rd(3'd5, 1, 8'h40 + 8'(i), "R11 stored byte");
    rd(3'd5, 1, 8'h00, "R11 seventeenth dropped");

    // R11 push while full with pop in the same cycle
    for (int i = 0; i < 16; i++) rxPush(8'h80 + 8'(i));
    @(negedge clk); #1; busAddr = 3'd5; busRdEn = 1; rxValid = 1; rxByte = 8'hEE;
    @(negedge clk); #1; busRdEn = 0; rxValid = 0;
    for (int i = 1; i < 16; i++) rd(3'd5, 1, 8'h80 + 8'(i), "R11 full pop");
    rd(3'd5, 1, 8'h00, "R11 arrival while full dropped");

    // push and pop together on a non-empty FIFO
    rxPush(8'hC1);
    @(negedge clk); #1; busAddr = 3'd5; busRdEn = 1; rxValid = 1; rxByte = 8'hC2;
    #5; check("R9 head during simultaneous", busRdData, 8'hC1);
    @(negedge clk); #1; busRdEn = 0; rxValid = 0;
    rd(3'd5, 1, 8'hC2, "R9 after simultaneous");

    // R3 flush
    rxPush(8'h01); rxPush(8'h02); rxPush(8'h03);
    wr(3'd1, 8'h00);
    rd(3'd0, 1, 8'h01, "R3 no flush on bit0=0");
    wr(3'd1, 8'h01);
    rd(3'd0, 1, 8'h05, "R3 flushed");
    rxPush(8'h07);
    @(negedge clk); #1; busAddr = 3'd1; busWrData = 8'h01; busWrEn = 1; rxValid = 1; rxByte = 8'h08;
    @(negedge clk); #1; busWrEn = 0; rxValid = 0;
    rd(3'd0, 1, 8'h05, "R3 flush beats arrival");
    rd(3'd5, 1, 8'h00, "R3 nothing left");

    // R2 parity flag
    @(negedge clk); #1; rxParityErr = 1;
    @(negedge clk); #1; rxParityErr = 0;
    rd(3'd0, 1, 8'h07, "R2 flag set");
    wr(3'd0, 8'h02);
    rd(3'd0, 1, 8'h07, "R2 write one keeps");
    wr(3'd0, 8'h00);
    rd(3'd0, 1, 8'h05, "R2 cleared");
    @(negedge clk); #1; busAddr = 3'd0; busWrData = 8'h00; busWrEn = 1; rxParityErr = 1;
    @(negedge clk); #1; busWrEn = 0; rxParityErr = 0;
    rd(3'd0, 1, 8'h07, "R2 set wins");
    wr(3'd0, 8'h00);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule